// File: doc/BRIEF.md
# PCI Bus Initiator Sequencer

This block runs one PCI transaction at a time on behalf of a local requester. A request gives a 4-bit command, a 32-bit address and a length. Once it is accepted, the block drives one address phase and then as many data phases as the length asks for. It drives the multiplexed AD bus and its enable, the C/BE# lines, FRAME# and IRDY#. It samples TRDY#, DEVSEL# and STOP# from the target.

Write words come from the local side through a valid/ready pair. Read words go back through a one-cycle `rd_valid` strobe, which the local side permits by raising `rd_space`. When the local side cannot supply or absorb a word, the block adds initiator wait states by leaving IRDY# high. Each transaction ends with a `done` pulse. If no target answers, it ends with an `err_noresp` pulse instead.

All bus outputs are registered and active-low where the bus defines them so. Arbitration, parity, retry recovery and 64-bit operation live elsewhere.

Top module: `pci_init_seq`

## Requirements
- R1: After reset, FRAME# and IRDY# are high, `ad_oe`, `done`, `err_noresp` and `rd_valid` are low, and `req_ready` is high while `req_cmd` holds a supported code.
- R2: A request is taken only while the bus is idle (FRAME# and IRDY# both high) and only for the codes 0110, 0111, 1010, 1011, 1100, 1110 and 1111. For any other code `req_ready` stays low and the bus stays idle.
- R3: In the clock after acceptance (the address phase), FRAME# is low, IRDY# is high, `ad_oe` is high, AD carries `req_addr` and C/BE# carries `req_cmd`. This lasts exactly one clock.
- R4: Codes with bit 0 set are writes. In a write data phase with IRDY# low, AD carries the latched word, C/BE# carries the inverse of `wr_be` (bit i enables byte i) and `ad_oe` is high. In every read data phase `ad_oe` is low and C/BE# is 0000.
- R5: IRDY# goes low for a data phase only if, at the edge that opens that phase, a write word was offered (`wr_valid` while `wr_ready`) or `rd_space` was high for a read. Otherwise the phase is an initiator wait state.
- R6: Once IRDY# is low, IRDY#, FRAME#, AD and C/BE# do not change until an edge with TRDY# or STOP# low, or a no-response abort.
- R7: A beat completes on each edge where IRDY# and TRDY# are both low. For a read, `rd_valid` pulses in the next clock with `rd_data` equal to the AD value sampled at that edge. For a write, the next word is taken through `wr_ready`.
- R8: With `req_len` = N, the transaction has N+1 beats. FRAME# goes high in the same clock that IRDY# goes low for the final beat, and stays low in all earlier phases.
- R9: In the clock after the final beat completes, FRAME# and IRDY# are high, `ad_oe` is low and `done` is high for one clock.
- R10: If DEVSEL# is not seen low in any of the first DEVSEL_WAIT data-phase clocks, the bus is idle in the next clock and `err_noresp` pulses for one clock without `done`.
- R11: An edge with STOP# and IRDY# both low ends the transaction: the bus is idle in the next clock and `done` pulses. The beat at that edge counts only if TRDY# is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | 32 | Start address |
| req_len | input | 4 | Beats minus one |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken at this edge |
| wr_data | input | 32 | Write word |
| wr_be | input | 4 | Active-high byte enables of the write word |
| rd_space | input | 1 | Local side can absorb a read word |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 32 | Read word |
| done | output | 1 | Transaction finished |
| err_noresp | output | 1 | Transaction ended without DEVSEL# |
| ad_out | output | 32 | AD value driven by the initiator |
| ad_oe | output | 1 | AD output enable |
| ad_in | input | 32 | AD value seen on the bus |
| cbe_n | output | 4 | Command / byte-enable lines |
| frame_n | output | 1 | FRAME# |
| irdy_n | output | 1 | IRDY# |
| trdy_n | input | 1 | TRDY# |
| devsel_n | input | 1 | DEVSEL# |
| stop_n | input | 1 | STOP# |

## Verification
The runs cover:
- Single-beat and sixteen-beat transfers, which separate the case where FRAME# rises straight after the address phase from the case where it rises on a late beat.
- Bursts where only the target inserts waits and bursts where only the local side does. These show whether a committed IRDY# is held, and whether a wait state is kept apart from a missing word.
- DEVSEL# arriving on the last permitted clock and never arriving, which tells a slow target from an absent one.
- STOP# arriving with and without TRDY#, which shows whether the final beat is counted correctly when the target cuts the transfer short.

// File: rtl/pci_init_pkg.sv
package pci_init_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;

  localparam logic [3:0] CMD_MEM_RD     = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD     = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR     = 4'b1011;
  localparam logic [3:0] CMD_MEM_RD_MUL = 4'b1100;
  localparam logic [3:0] CMD_MEM_RD_LN  = 4'b1110;
  localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

  function automatic logic cmd_supported(input logic [3:0] c);
    case (c)
      CMD_MEM_RD, CMD_MEM_WR, CMD_CFG_RD, CMD_CFG_WR,
      CMD_MEM_RD_MUL, CMD_MEM_RD_LN, CMD_MEM_WR_INV: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pci_beat_left.sv
module pci_beat_left #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_one,
  output logic             is_two
);
  logic [CNT_W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (load)      left_d = load_val;
    else if (dec)  left_d = left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (load || dec)  left_q <= left_d;
  end

  assign is_one = (left_q == CNT_W'(1));
  assign is_two = (left_q == CNT_W'(2));
endmodule

// File: rtl/pci_devsel_timer.sv
module pci_devsel_timer #(
  parameter int WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic devsel_n,
  output logic abort
);
  localparam int CW = $clog2(WAIT + 1);

  logic          seen_q, seen_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign abort = active && !seen_q && devsel_n && (cnt_q == CW'(WAIT - 1));

  always_comb begin
    seen_d = seen_q;
    cnt_d  = cnt_q;
    if (start) begin
      seen_d = 1'b0;
      cnt_d  = '0;
    end else if (!devsel_n) begin
      seen_d = 1'b1;
    end else if (!seen_q && cnt_q != CW'(WAIT - 1)) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  assign en = start || active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/pci_init_seq.sv
module pci_init_seq
  import pci_init_pkg::*;
#(
  parameter int DW          = 32,
  parameter int LEN_W       = 4,
  parameter int DEVSEL_WAIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          req_cmd,
  input  logic [DW-1:0]       req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [DW-1:0]       wr_data,
  input  logic [DW/8-1:0]     wr_be,
  input  logic                rd_space,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                done,
  output logic                err_noresp,
  output logic [DW-1:0]       ad_out,
  output logic                ad_oe,
  input  logic [DW-1:0]       ad_in,
  output logic [DW/8-1:0]     cbe_n,
  output logic                frame_n,
  output logic                irdy_n,
  input  logic                trdy_n,
  input  logic                devsel_n,
  input  logic                stop_n
);
  localparam int BE_W  = DW / 8;
  localparam int CNT_W = LEN_W + 1;

  seq_state_e      state_q, state_d;
  logic            frame_q, frame_d, irdy_q, irdy_d, oe_q, oe_d;
  logic [DW-1:0]   ad_q, ad_d, rd_q, rd_d;
  logic [BE_W-1:0] cbe_q, cbe_d;
  logic            wr_q, wr_d, done_q, done_d, err_q, err_d, rv_q, rv_d;

  logic accept, beat_done, stop_evt, load_slot, go, last_eff, abort;
  logic left_one, left_two, in_data;

  assign in_data   = (state_q == ST_DATA);
  assign req_ready = (state_q == ST_IDLE) && cmd_supported(req_cmd);
  assign accept    = req_valid && req_ready;
  assign beat_done = in_data && !irdy_q && !trdy_n;
  assign stop_evt  = in_data && !irdy_q && !stop_n;
  assign load_slot = (state_q == ST_ADDR) ||
                     (in_data && !abort && (irdy_q || (beat_done && stop_n && !left_one)));
  assign go        = wr_q ? wr_valid : rd_space;
  assign last_eff  = beat_done ? left_two : left_one;
  assign wr_ready  = load_slot && wr_q;

  pci_beat_left #(.CNT_W(CNT_W)) u_left (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val ({1'b0, req_len} + CNT_W'(1)),
    .dec      (beat_done && !abort),
    .is_one   (left_one),
    .is_two   (left_two)
  );

  pci_devsel_timer #(.WAIT(DEVSEL_WAIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .active   (in_data),
    .devsel_n (devsel_n),
    .abort    (abort)
  );

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    irdy_d  = irdy_q;
    oe_d    = oe_q;
    ad_d    = ad_q;
    cbe_d   = cbe_q;
    wr_d    = wr_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    rv_d    = 1'b0;
    rd_d    = beat_done ? ad_in : rd_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_ADDR;
        frame_d = 1'b0;
        irdy_d  = 1'b1;
        oe_d    = 1'b1;
        ad_d    = req_addr;
        cbe_d   = BE_W'(req_cmd);
        wr_d    = req_cmd[0];
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (abort) begin
          err_d = 1'b1;
        end else if (stop_evt) begin
          done_d = 1'b1;
          rv_d   = !trdy_n && !wr_q;
        end else if (beat_done) begin
          rv_d   = !wr_q;
          done_d = left_one;
        end
        if (abort || stop_evt || (beat_done && left_one)) begin
          state_d = ST_IDLE;
          frame_d = 1'b1;
          irdy_d  = 1'b1;
          oe_d    = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (load_slot) begin
      oe_d = wr_q;
      if (!wr_q) cbe_d = '0;
      if (go) begin
        irdy_d  = 1'b0;
        frame_d = last_eff;
        if (wr_q) begin
          ad_d  = wr_data;
          cbe_d = ~wr_be;
        end
      end else begin
        irdy_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b1;
      irdy_q  <= 1'b1;
      oe_q    <= 1'b0;
      ad_q    <= '0;
      cbe_q   <= '1;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      irdy_q  <= irdy_d;
      oe_q    <= oe_d;
      ad_q    <= ad_d;
      cbe_q   <= cbe_d;
      wr_q    <= wr_d;
      done_q  <= done_d;
      err_q   <= err_d;
      rv_q    <= rv_d;
      rd_q    <= rd_d;
    end
  end

  assign frame_n    = frame_q;
  assign irdy_n     = irdy_q;
  assign ad_oe      = oe_q;
  assign ad_out     = ad_q;
  assign cbe_n      = cbe_q;
  assign done       = done_q;
  assign err_noresp = err_q;
  assign rd_valid   = rv_q;
  assign rd_data    = rd_q;
endmodule

// File: rtl/pci_init_seq_chk.sv
module pci_init_seq_chk #(
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_n,
  input logic            irdy_n,
  input logic            trdy_n,
  input logic            stop_n,
  input logic            ad_oe,
  input logic [DW-1:0]   ad_out,
  input logic [DW/8-1:0] cbe_n,
  input logic            done,
  input logic            err_noresp,
  input logic            abort
);
  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(irdy_n) && $past(frame_n));

  // R3
  addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> irdy_n && ad_oe);

  // R6
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && trdy_n && stop_n && !abort) |=>
      $stable(irdy_n) && $stable(frame_n) && $stable(ad_out) && $stable(cbe_n));

  // R9
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n && frame_n && !abort) |=> frame_n && irdy_n && !ad_oe && done);

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_noresp |-> frame_n && irdy_n && !done);

  // R9
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_noresp}));
endmodule

bind pci_init_seq pci_init_seq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .trdy_n     (trdy_n),
  .stop_n     (stop_n),
  .ad_oe      (ad_oe),
  .ad_out     (ad_out),
  .cbe_n      (cbe_n),
  .done       (done),
  .err_noresp (err_noresp),
  .abort      (abort)
);

// File: tb/pci_init_seq_bench.sv
`timescale 1ns/1ps
module pci_init_seq_bench;
  localparam int WAITC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_cmd = 4'b0110;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rd_space = 1'b0, rd_valid;
  logic [31:0] rd_data;
  logic        done, err_noresp;
  logic [31:0] ad_out, ad_in = '0;
  logic        ad_oe;
  logic [3:0]  cbe_n;
  logic        frame_n, irdy_n;
  logic        trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pci_init_seq u_pci_init_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_be(wr_be),
    .rd_space(rd_space), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .err_noresp(err_noresp), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n)
  );

  function automatic bit ok_cmd(input logic [3:0] c);
    return c == 4'b0110 || c == 4'b0111 || c == 4'b1010 || c == 4'b1011 ||
           c == 4'b1100 || c == 4'b1110 || c == 4'b1111;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 address, 2 data
  int          ms, left, cnt;
  bit          seen, mwr;
  logic        e_frame, e_irdy, e_oe, e_done, e_err, e_rv;
  logic [31:0] e_ad, e_rd;
  logic [3:0]  e_cbe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; left = 0; cnt = 0; seen = 0; mwr = 0;
      e_frame = 1; e_irdy = 1; e_oe = 0; e_done = 0; e_err = 0; e_rv = 0;
      e_ad = 0; e_rd = 0; e_cbe = 4'hF;
    end else begin
      bit committed, bd, ab, slot, fin;
      committed = !e_irdy;
      bd   = (ms == 2) && committed && !trdy_n;
      ab   = (ms == 2) && !seen && devsel_n && cnt == WAITC - 1;
      slot = 0; fin = 0;
      e_done = 0; e_err = 0; e_rv = 0;
      if (bd) e_rd = ad_in;
      if (ms == 0) begin
        if (req_valid && ok_cmd(req_cmd)) begin
          ms = 1; e_frame = 0; e_irdy = 1; e_oe = 1; e_ad = req_addr; e_cbe = req_cmd;
          mwr = req_cmd[0]; left = req_len + 1; cnt = 0; seen = 0;
        end
      end else if (ms == 1) begin
        ms = 2; slot = 1;
      end else begin
        if (!devsel_n) seen = 1;
        else if (!seen && cnt != WAITC - 1) cnt++;
        if (ab) begin
          fin = 1; e_err = 1;
        end else if (committed) begin
          if (!stop_n) begin
            if (!trdy_n && !mwr) e_rv = 1;
            fin = 1; e_done = 1;
          end else if (!trdy_n) begin
            if (!mwr) e_rv = 1;
            left--;
            if (left == 0) begin fin = 1; e_done = 1; end
            else slot = 1;
          end
        end else slot = 1;
      end
      if (fin) begin ms = 0; e_frame = 1; e_irdy = 1; e_oe = 0; end
      if (slot) begin
        e_oe = mwr;
        if (!mwr) e_cbe = 4'h0;
        if (mwr ? wr_valid : rd_space) begin
          e_irdy = 0; e_frame = (left == 1);
          if (mwr) begin e_ad = wr_data; e_cbe = ~wr_be; end
        end else e_irdy = 1;
      end
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ab;
      logic exp_wrr;
      ab = (ms == 2) && !seen && devsel_n && cnt == WAITC - 1;
      exp_wrr = mwr && (ms == 1 ||
                (ms == 2 && !ab && (e_irdy || (!trdy_n && stop_n && left > 1))));
      chk("R8 frame_n", frame_n, e_frame);
      chk("R5/R6 irdy_n", irdy_n, e_irdy);
      chk("R4 ad_oe", ad_oe, e_oe);
      if (e_oe) chk(ms == 1 ? "R3 ad_out" : "R4 ad_out", ad_out, e_ad);
      if (ms == 1) chk("R3 cbe_n", cbe_n, e_cbe);
      if (ms == 2 && (!mwr || !e_irdy)) chk("R4 cbe_n", cbe_n, e_cbe);
      chk("R9 done", done, e_done);
      chk("R10 err_noresp", err_noresp, e_err);
      chk("R7 rd_valid", rd_valid, e_rv);
      if (e_rv) chk("R7 rd_data", rd_data, e_rd);
      chk("R2 req_ready", req_ready, (ms == 0) && ok_cmd(req_cmd));
      chk("R5 wr_ready", wr_ready, exp_wrr);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic drive(input int k, input int dsel, input int tw, input int lw, input int stopk);
    devsel_n = !(k >= 1 && k >= dsel);
    trdy_n   = !(k >= 1 && k >= dsel && (k % tw) == 0);
    stop_n   = !(stopk != 0 && k >= stopk);
    wr_valid = ((k + 1) % lw) == 0;
    rd_space = ((k + 1) % lw) == 0;
    wr_data  = 32'h5A00_0000 + k * 32'h0101;
    wr_be    = 4'(k) | 4'b0001;
    ad_in    = 32'hC0DE_0000 + k * 17;
  endtask

  task automatic txn(input logic [3:0] c, input logic [31:0] a, input int len,
                     input int dsel, input int tw, input int lw, input int stopk);
    int k;
    k = 0;
    req_cmd = c; req_addr = a; req_len = 4'(len); req_valid = 1;
    drive(0, dsel, tw, lw, stopk);
    @(posedge clk); #1;
    req_valid = 0;
    for (int i = 0; i < 400; i++) begin
      drive(k, dsel, tw, lw, stopk);
      @(posedge clk); #1;
      if (ms == 0) break;
      k++;
    end
    devsel_n = 1; trdy_n = 1; stop_n = 1; wr_valid = 0; rd_space = 0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1 frame_n", frame_n, 1'b1);
    chk("R1 irdy_n", irdy_n, 1'b1);
    chk("R1 ad_oe", ad_oe, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 err_noresp", err_noresp, 1'b0);
    chk("R1 rd_valid", rd_valid, 1'b0);
    chk("R1 req_ready", req_ready, 1'b1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2: unsupported code held for several clocks leaves the bus idle
    req_cmd = 4'b0101; req_valid = 1;
    repeat (3) @(posedge clk);
    #1;
    req_valid = 0; req_cmd = 4'b0110;

    txn(4'b0111, 32'h1000_0000, 0, 1, 1, 1, 0);   // R8 single-beat write
    txn(4'b0111, 32'h1000_0040, 3, 1, 2, 1, 0);   // R6 target waits on a committed beat
    txn(4'b0111, 32'h1000_0080, 3, 2, 1, 3, 0);   // R5 initiator waits for write words
    txn(4'b0110, 32'h2000_0000, 0, 2, 1, 1, 0);   // R7 single-beat read
    txn(4'b1100, 32'h2000_0100, 4, 1, 3, 2, 0);   // R5/R7 mixed waits on read
    txn(4'b1110, 32'h2000_0200, 15, 1, 1, 1, 0);  // R8 longest burst
    txn(4'b1011, 32'h0000_0010, 1, 4, 1, 1, 0);   // R10 DEVSEL on last allowed clock
    txn(4'b1010, 32'h0000_0020, 2, 99, 1, 1, 0);  // R10 no target answers
    txn(4'b1111, 32'h3000_0000, 5, 1, 1, 1, 3);   // R11 STOP with TRDY
    txn(4'b0110, 32'h3000_0100, 5, 1, 2, 1, 5);   // R11 STOP without TRDY
    txn(4'b0110, 32'h3000_0200, 2, 1, 1, 1, 0);   // R9 back to idle and again

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule